// File: doc/BRIEF.md
# Compare-Match Timer

An 8-bit up-counter runs against an 8-bit compare value. When the two are equal on a counting cycle, the block raises a sticky interrupt flag. It also performs a programmable action on a single output pin: toggle it, drive it low, or drive it high. Optionally, it returns the counter to zero. A one-byte control register holds the pin action, the clear-on-match enable, a PWM enable and a three-bit clock select. It also holds a force strobe, which performs the programmed pin action immediately, as if a match had happened.

Software reaches the block through a simple synchronous register port with a write strobe, a 2-bit address, write data and combinational read data. A prescaler outside the block supplies a count-enable pulse. The counter advances only on cycles where that pulse is high and the clock select is non-zero.

Top module: `cmp_timer`

## Requirements
- R1: After reset, every register reads 0, and `cmp_pin_o`, `cmp_pin_oe_o` and `irq_o` are all 0.
- R2: The register map is as follows. Address 0 is the control byte, which holds force at bit 7, PWM enable at bit 6, pin mode at bits 5:4, clear-on-match at bit 3 and clock select at bits 2:0. Address 1 is the counter, address 2 is the compare value, and address 3 is the flag at bit 0. Bit 7 of the control byte always reads 0.
- R3: The counter advances by one at each edge where `cnt_en_i` is 1 and the clock select is non-zero, wrapping from 255 to 0. Otherwise it holds. A bus write to the counter takes priority over counting and clearing.
- R4: A match exists on a cycle when `cnt_en_i` is 1, the clock select is non-zero and the counter equals the compare value. A match sets the flag at the following edge. The flag stays set until 1 is written to bit 0 of address 3, and a match in that same cycle wins over the clear. `irq_o` follows the flag.
- R5: When clear-on-match is 1, the edge that ends a match cycle loads the counter with 0. When clear-on-match is 0, a match does not affect counting.
- R6: At the edge that ends a match cycle, the pin mode sets the pin action. Mode 01 inverts `cmp_pin_o`, mode 10 drives it to 0, and mode 11 drives it to 1.
- R7: In pin mode 00, `cmp_pin_oe_o` is 0 and `cmp_pin_o` keeps its last level. In any other mode, `cmp_pin_oe_o` is 1.
- R8: Writing the control byte with bit 7 set performs the pin action at that write's edge. The force sets no flag and never clears the counter, even when clear-on-match is 1.
- R9: A forced action uses the pin mode held before the write. A mode written together with the force governs only later actions.
- R10: The force is inert if the PWM enable is 1, either in the stored control byte or in the byte being written.
- R11: If a match and a force fall in the same cycle, the pin action is applied once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for `reg_addr_i` |
| cnt_en_i | input | 1 | Count enable from the prescaler |
| cmp_pin_o | output | 1 | Compare output pin level |
| cmp_pin_oe_o | output | 1 | Pin driven by the compare unit |
| irq_o | output | 1 | Compare-match interrupt flag |

## Verification
The bench builds the block with its default 8-bit data width and 2-bit address width. This puts the 255-to-0 wrap and every compare value within reach of a few hundred random cycles. Random writes, including writes to the counter that move it close to the compare value, make matches frequent. Matches then coincide with force strobes, flag clears and mode changes far more often than they would in a free-running count.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;
  localparam int unsigned AW = 2;

  localparam logic [AW-1:0] ADDR_CTRL = 2'd0;
  localparam logic [AW-1:0] ADDR_CNT  = 2'd1;
  localparam logic [AW-1:0] ADDR_CMP  = 2'd2;
  localparam logic [AW-1:0] ADDR_FLAG = 2'd3;

  typedef enum logic [1:0] {
    PIN_OFF = 2'b00,
    PIN_TGL = 2'b01,
    PIN_LO  = 2'b10,
    PIN_HI  = 2'b11
  } pin_mode_e;

  typedef struct packed {
    logic      force_cmp;
    logic      pwm_en;
    pin_mode_e mode;
    logic      clr_on_match;
    logic [2:0] clk_sel;
  } ctrl_t;
endpackage

// File: rtl/cmp_timer_regs.sv
module cmp_timer_regs
  import cmp_timer_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] cnt_i,
  input  logic          match_i,
  output ctrl_t         ctrl_o,
  output logic [DW-1:0] cmp_o,
  output logic          flag_o,
  output logic          force_o,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned CW = $bits(ctrl_t);

  ctrl_t         ctrl_q;
  logic [DW-1:0] cmp_q;
  logic          flag_q;
  logic          wr_ctrl, wr_cmp, wr_flag;
  ctrl_t         wr_byte;

  assign wr_ctrl = we_i && (addr_i == ADDR_CTRL);
  assign wr_cmp  = we_i && (addr_i == ADDR_CMP);
  assign wr_flag = we_i && (addr_i == ADDR_FLAG);
  assign wr_byte = ctrl_t'(wdata_i[CW-1:0]);

  // strobe is inert when PWM is set in stored or incoming byte
  assign force_o = wr_ctrl && wr_byte.force_cmp && !wr_byte.pwm_en && !ctrl_q.pwm_en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      cmp_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q           <= wr_byte;
        ctrl_q.force_cmp <= 1'b0;
      end
      if (wr_cmp) cmp_q <= wdata_i;
      if (match_i)                 flag_q <= 1'b1;
      else if (wr_flag && wdata_i[0]) flag_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_CTRL: rdata_o[CW-1:0] = ctrl_q;
      ADDR_CNT:  rdata_o = cnt_i;
      ADDR_CMP:  rdata_o = cmp_q;
      ADDR_FLAG: rdata_o[0] = flag_q;
      default:   rdata_o = '0;
    endcase
  end

  assign ctrl_o = ctrl_q;
  assign cmp_o  = cmp_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/cmp_timer_cnt.sv
module cmp_timer_cnt #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          run_i,
  input  logic          clr_on_match_i,
  input  logic [DW-1:0] cmp_i,
  input  logic          load_i,
  input  logic [DW-1:0] load_val_i,
  output logic [DW-1:0] cnt_o,
  output logic          match_o
);
  logic [DW-1:0] cnt_q;
  logic          step;

  assign step    = en_i && run_i;
  assign match_o = step && (cnt_q == cmp_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (load_i)                   cnt_q <= load_val_i;
    else if (match_o && clr_on_match_i) cnt_q <= '0;
    else if (step)                     cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/cmp_timer_ocu.sv
module cmp_timer_ocu
  import cmp_timer_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  pin_mode_e mode_i,
  input  logic      act_i,
  output logic      pin_o,
  output logic      oe_o
);
  logic pin_q, pin_d;

  always_comb begin
    pin_d = pin_q;
    if (act_i) begin
      unique case (mode_i)
        PIN_TGL: pin_d = ~pin_q;
        PIN_LO:  pin_d = 1'b0;
        PIN_HI:  pin_d = 1'b1;
        default: pin_d = pin_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_q <= 1'b0;
    else         pin_q <= pin_d;
  end

  assign pin_o = pin_q;
  assign oe_o  = (mode_i != PIN_OFF);
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
  import cmp_timer_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [1:0]    reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  input  logic          cnt_en_i,
  output logic          cmp_pin_o,
  output logic          cmp_pin_oe_o,
  output logic          irq_o
);
  ctrl_t         ctrl_q;
  logic [DW-1:0] cmp_q;
  logic [DW-1:0] cnt_q;
  logic          match;
  logic          force_act;
  logic          flag_q;
  logic          cnt_load;

  assign cnt_load = reg_we_i && (reg_addr_i == ADDR_CNT);

  cmp_timer_regs #(.DW(DW)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .cnt_i   (cnt_q),
    .match_i (match),
    .ctrl_o  (ctrl_q),
    .cmp_o   (cmp_q),
    .flag_o  (flag_q),
    .force_o (force_act),
    .rdata_o (reg_rdata_o)
  );

  cmp_timer_cnt #(.DW(DW)) u_cnt (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .en_i           (cnt_en_i),
    .run_i          (ctrl_q.clk_sel != 3'b000),
    .clr_on_match_i (ctrl_q.clr_on_match),
    .cmp_i          (cmp_q),
    .load_i         (cnt_load),
    .load_val_i     (reg_wdata_i),
    .cnt_o          (cnt_q),
    .match_o        (match)
  );

  // action uses the mode held before any same-cycle control write
  cmp_timer_ocu u_ocu (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode_i (ctrl_q.mode),
    .act_i  (match || force_act),
    .pin_o  (cmp_pin_o),
    .oe_o   (cmp_pin_oe_o)
  );

  assign irq_o = flag_q;
endmodule

// File: rtl/cmp_timer_chk.sv
module cmp_timer_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          reg_we_i,
  input logic [1:0]    reg_addr_i,
  input logic [DW-1:0] reg_rdata_o,
  input logic          cnt_en_i,
  input logic          cmp_pin_o,
  input logic          cmp_pin_oe_o,
  input logic          irq_o,
  input logic          match,
  input logic          force_act,
  input logic [DW-1:0] cnt_q,
  input logic [7:0]    ctrl_bits
);
  logic cnt_wr;
  assign cnt_wr = reg_we_i && (reg_addr_i == 2'd1);

  a_r2_force_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == 2'd0) |-> (reg_rdata_o[7] == 1'b0));

  a_r4_match_sets_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match |=> irq_o);

  a_r5_clear_on_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match && ctrl_bits[3] && !cnt_wr) |=> (cnt_q == '0));

  a_r6_drive_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match && ctrl_bits[5:4] == 2'b11) |=> cmp_pin_o);

  a_r7_off_holds_pin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmp_pin_oe_o |=> $stable(cmp_pin_o));

  a_r8_force_no_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (force_act && !match && !irq_o) |=> !irq_o);

  a_r8_force_no_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (force_act && !match && !cnt_en_i && !cnt_wr) |=> $stable(cnt_q));
endmodule

bind cmp_timer cmp_timer_chk #(.DW(DW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .reg_we_i     (reg_we_i),
  .reg_addr_i   (reg_addr_i),
  .reg_rdata_o  (reg_rdata_o),
  .cnt_en_i     (cnt_en_i),
  .cmp_pin_o    (cmp_pin_o),
  .cmp_pin_oe_o (cmp_pin_oe_o),
  .irq_o        (irq_o),
  .match        (match),
  .force_act    (force_act),
  .cnt_q        (cnt_q),
  .ctrl_bits    (ctrl_q)
);

// File: tb/cmp_timer_tb_top.sv
`timescale 1ns/1ps
module cmp_timer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wd = '0;
  logic [7:0] rd;
  logic       en = 1'b0;
  logic       pin, oe, irq;

  int n_chk = 0;
  int n_fail = 0;

  logic [7:0] m_ctrl = '0, m_cnt = '0, m_cmp = '0;
  logic       m_pin = 1'b0, m_flag = 1'b0;

  always #2.5 clk = ~clk;

  cmp_timer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wd), .reg_rdata_o(rd), .cnt_en_i(en),
    .cmp_pin_o(pin), .cmp_pin_oe_o(oe), .irq_o(irq)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] m_read(input logic [1:0] a);
    case (a)
      2'd0: return {1'b0, m_ctrl[6:0]};
      2'd1: return m_cnt;
      2'd2: return m_cmp;
      default: return {7'd0, m_flag};
    endcase
  endfunction

  // one clock with given inputs; model advances in step
  task automatic cyc(input logic w, input logic [1:0] a, input logic [7:0] d, input logic e);
    logic run, mt, frc, act;
    logic [7:0] n_cnt;
    we = w; addr = a; wd = d; en = e;
    #1;
    if (!w) chk(rd, m_read(a), "R2 read");
    run = (m_ctrl[2:0] != 3'd0);
    mt  = e && run && (m_cnt == m_cmp);
    frc = w && a == 2'd0 && d[7] && !d[6] && !m_ctrl[6];
    act = mt || frc;
    n_cnt = m_cnt;
    if (w && a == 2'd1) n_cnt = d;
    else if (mt && m_ctrl[3]) n_cnt = 8'd0;
    else if (e && run) n_cnt = m_cnt + 8'd1;
    @(posedge clk);
    if (act) case (m_ctrl[5:4])
      2'b01: m_pin = ~m_pin;
      2'b10: m_pin = 1'b0;
      2'b11: m_pin = 1'b1;
      default: ;
    endcase
    if (mt) m_flag = 1'b1;
    else if (w && a == 2'd3 && d[0]) m_flag = 1'b0;
    m_cnt = n_cnt;
    if (w && a == 2'd2) m_cmp = d;
    if (w && a == 2'd0) m_ctrl = {1'b0, d[6:0]};
    @(negedge clk);
    we = 1'b0; en = 1'b0;
    chk({7'd0, pin}, {7'd0, m_pin}, "R6 pin");
    chk({7'd0, oe}, {7'd0, m_ctrl[5:4] != 2'b00}, "R7 oe");
    chk({7'd0, irq}, {7'd0, m_flag}, "R4 irq");
  endtask

  task automatic peek(input logic [1:0] a, input logic [7:0] exp, input string tag);
    we = 1'b0; addr = a; #1;
    chk(rd, exp, tag);
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 4; a++) peek(a[1:0], 8'h00, "R1 reg");
    chk({5'd0, pin, oe, irq}, 8'h00, "R1 outputs");

    // R5/R6: mode high, clear-on-match, cmp 5
    cyc(1, 2'd2, 8'd5, 0);
    cyc(1, 2'd0, 8'h39, 0);
    for (int i = 0; i < 6; i++) cyc(0, 2'd1, 8'h00, 1);
    chk({7'd0, pin}, 8'd1, "R6 high on match");
    chk({7'd0, irq}, 8'd1, "R4 flag set");
    peek(2'd1, 8'd0, "R5 cleared after match");
    // R4 clear by write one
    cyc(1, 2'd3, 8'h01, 0);
    chk({7'd0, irq}, 8'd0, "R4 flag clear");

    // R9: mode 10 stored, force with new mode 11 -> old mode applies
    cyc(1, 2'd0, 8'h29, 0);
    cyc(1, 2'd0, 8'hB9, 0);
    chk({7'd0, pin}, 8'd0, "R9 old mode on force");
    peek(2'd0, 8'h39, "R2 force reads zero");
    cyc(1, 2'd0, 8'hA9, 0);
    chk({7'd0, pin}, 8'd1, "R9 new mode next force");
    chk({7'd0, irq}, 8'd0, "R8 no flag on force");
    // R8 no clear with clear-on-match
    cyc(1, 2'd1, 8'd77, 0);
    cyc(1, 2'd0, 8'hA9, 0);
    peek(2'd1, 8'd77, "R8 counter kept");

    // R10: stored PWM, then written PWM
    cyc(1, 2'd0, 8'h69, 0);
    cyc(1, 2'd0, 8'hE9, 0);
    chk({7'd0, pin}, 8'd0, "R10 stored pwm inert");
    cyc(1, 2'd0, 8'h29, 0);
    cyc(1, 2'd0, 8'hF9, 0);
    chk({7'd0, pin}, 8'd0, "R10 written pwm inert");

    // R11: match and force together, toggle mode
    cyc(1, 2'd0, 8'h11, 0);
    cyc(1, 2'd2, 8'd20, 0);
    cyc(1, 2'd1, 8'd20, 0);
    en = 1'b1;
    cyc(1, 2'd0, 8'h91, 1);
    chk({7'd0, pin}, 8'd1, "R11 single toggle");

    // R7: mode off holds level
    cyc(1, 2'd0, 8'h01, 0);
    cyc(1, 2'd1, 8'd20, 0);
    cyc(0, 2'd0, 8'h00, 1);
    chk({6'd0, pin, oe}, 8'b10, "R7 hold and oe low");

    // R3: wrap and stop
    cyc(1, 2'd1, 8'hFF, 0);
    cyc(0, 2'd1, 8'h00, 1);
    peek(2'd1, 8'h00, "R3 wrap");
    cyc(1, 2'd0, 8'h00, 0);
    cyc(0, 2'd1, 8'h00, 1);
    peek(2'd1, 8'h00, "R3 clock select zero holds");

    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] d;
      logic [1:0] a;
      logic w;
      a = 2'($urandom_range(0, 3));
      w = ($urandom_range(0, 3) == 0);
      d = 8'($urandom);
      if (a == 2'd0 && ($urandom_range(0, 3) != 0)) d[6] = 1'b0;
      if (a == 2'd1) d = m_cmp - 8'($urandom_range(0, 3));
      cyc(w, a, d, ($urandom_range(0, 2) != 0));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule